// File: doc/BRIEF.md
# Output-Compare Timer with Master Override

This block is a multi-channel output-compare timer built around one free-running up counter. Each channel holds a compare value and a two-bit action code. When the counter equals a channel's compare value, the block sets, clears or toggles that channel's output pin. The highest-numbered channel is the master. When its event fires, any chosen subset of pins is forced to programmed levels through a mask and a level register. On the same cycle this forcing takes precedence over each channel's own action.

The master match can also send the counter back to zero. The master compare value then sets a waveform period, and a second channel's compare value sets the pulse width. The result is a PWM output that runs with no processor work once it is set up. Counter overflow can serve as an extra source of master events. Software programs the block through a simple synchronous write port and a combinational read port.

Top module: `ocmp_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the counter, all event flags and all pins to 0. The configuration registers are also cleared.
- R2: The register map is 0 counter (a write loads it), 1 control, 2 output-compare enable (bit i = channel i), 3 action codes (channel i in bits 2i+1:2i), 4 master mask, 5 master levels, 6 event flags and 8+i compare value of channel i. Control bit 0 runs the counter, bit 1 enables return-to-zero on a master match, and bit 2 makes overflow a master event. A write takes effect at the next clock edge.
- R3: While control bit 0 is 1, the counter advances by one each cycle and wraps from 0xFFFF to 0. While that bit is 0 it holds its value.
- R4: A channel's action code applies only to its own pin, one cycle after the counter equals its compare value while running. Code 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R5: A pin never changes while its output-compare enable bit is 0, whether the cause is its own action or a master event.
- R6: Each channel's event flag is set when the counter matches its compare value while running. Matches are not evaluated while the counter is stopped. A flag stays set until 1 is written to its bit at address 6. Writing 0 to a bit leaves that flag unchanged.
- R7: A master event needs the master channel (index NCH-1) to be enabled and either a compare match or, with control bit 2 set, a counter overflow. On a master event, each enabled pin whose mask bit is 1 takes the matching level bit at the next edge.
- R8: When a channel's match and a master event fall in the same cycle and the channel's mask bit is 1, the master level wins over the channel's action code.
- R9: The master channel's own pin follows its level bit whenever its mask bit is 1, even if its own action code is non-zero. With the mask bit 0, it follows its action code.
- R10: When a channel match and a master event occur in different cycles, both take effect in time order.
- R11: With control bit 1 set, the counter returns to 0 on the cycle after it equals the master compare value P. The period is therefore P+1 cycles.
- R12: In PWM use (period P, width W < P, action 11 on the channel, master mask 1 and level 0), the counter shows c after each edge and the pin is 1 exactly when W < c <= P.
- R13: Counter overflow produces a master event only when control bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CW | Read data, combinational from rd_addr |
| pin_o | output | NCH | Registered compare output pins |

## Verification
The assertions assume that `rst` is held for at least one edge before any traffic. They also assume that a write to the counter only redirects counting, so the increment and return-to-zero properties exclude cycles with a counter load. Every stimulus sequence loads the counter only while it is stopped, or in a dedicated cycle, and each run is opened and closed through the control register. The stimulus sets compare values away from the counter's path to isolate one channel at a time. It keeps `wr_addr` within the map so that no write lands outside it.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int AW = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    localparam logic [AW-1:0] A_COUNT  = 4'd0;
    localparam logic [AW-1:0] A_CTRL   = 4'd1;
    localparam logic [AW-1:0] A_ENABLE = 4'd2;
    localparam logic [AW-1:0] A_ACTION = 4'd3;
    localparam logic [AW-1:0] A_MASK   = 4'd4;
    localparam logic [AW-1:0] A_LEVEL  = 4'd5;
    localparam logic [AW-1:0] A_FLAGS  = 4'd6;
    localparam logic [AW-1:0] A_CMP0   = 4'd8;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_WRAP = 1;
    localparam int CTRL_OVF  = 2;
endpackage

// File: rtl/ocmp_regfile.sv
module ocmp_regfile
    import ocmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    output logic                     run_o,
    output logic                     wrap_o,
    output logic                     ovf_o,
    output logic [NCH-1:0]           en_o,
    output logic [2*NCH-1:0]         act_o,
    output logic [NCH-1:0]           mask_o,
    output logic [NCH-1:0]           level_o,
    output logic [NCH-1:0][CW-1:0]   cmp_o
);
    typedef struct packed {
        logic                   run;
        logic                   wrap;
        logic                   ovf;
        logic [NCH-1:0]         en;
        logic [2*NCH-1:0]       act;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         level;
        logic [NCH-1:0][CW-1:0] cmp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                cfg_d.run  = wr_data[CTRL_RUN];
                cfg_d.wrap = wr_data[CTRL_WRAP];
                cfg_d.ovf  = wr_data[CTRL_OVF];
            end
            if (wr_addr == A_ENABLE) cfg_d.en    = wr_data[NCH-1:0];
            if (wr_addr == A_ACTION) cfg_d.act   = wr_data[2*NCH-1:0];
            if (wr_addr == A_MASK)   cfg_d.mask  = wr_data[NCH-1:0];
            if (wr_addr == A_LEVEL)  cfg_d.level = wr_data[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == A_CMP0 + AW'(i)) cfg_d.cmp[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign run_o   = cfg_q.run;
    assign wrap_o  = cfg_q.wrap;
    assign ovf_o   = cfg_q.ovf;
    assign en_o    = cfg_q.en;
    assign act_o   = cfg_q.act;
    assign mask_o  = cfg_q.mask;
    assign level_o = cfg_q.level;
    assign cmp_o   = cfg_q.cmp;
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wrap_en,
    input  logic [CW-1:0] top,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_o,
    output logic          at_max_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (run) begin
            if (wrap_en && (st_q.cnt == top)) st_d.cnt = '0;
            else                              st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign at_max_o = run && (&st_q.cnt);
endmodule

// File: rtl/ocmp_compare.sv
module ocmp_compare #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                   run,
    input  logic [NCH-1:0]         en,
    input  logic                   ovf_en,
    input  logic                   at_max,
    input  logic [CW-1:0]          cnt,
    input  logic [NCH-1:0][CW-1:0] cmp,
    output logic [NCH-1:0]         match_o,
    output logic                   master_o
);
    localparam int MST = NCH - 1;

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign match_o[i] = run && (cnt == cmp[i]);
    end

    assign master_o = en[MST] && (match_o[MST] || (ovf_en && at_max));
endmodule

// File: rtl/ocmp_outputs.sv
module ocmp_outputs
    import ocmp_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*NCH-1:0]   act,
    input  logic [NCH-1:0]     en,
    input  logic [NCH-1:0]     match,
    input  logic               master,
    input  logic [NCH-1:0]     mask,
    input  logic [NCH-1:0]     level,
    input  logic [NCH-1:0]     clr,
    output logic [NCH-1:0]     pins_o,
    output logic [NCH-1:0]     flags_o
);
    typedef struct packed {
        logic [NCH-1:0] pins;
        logic [NCH-1:0] flags;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (en[i] && match[i]) begin
                case (act_e'(act[2*i +: 2]))
                    ACT_TOGGLE: st_d.pins[i] = ~st_q.pins[i];
                    ACT_LOW:    st_d.pins[i] = 1'b0;
                    ACT_HIGH:   st_d.pins[i] = 1'b1;
                    default:    st_d.pins[i] = st_q.pins[i];
                endcase
            end
            if (en[i] && master && mask[i]) st_d.pins[i] = level[i];
        end
        st_d.flags = (st_q.flags & ~clr) | match;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pins_o  = st_q.pins;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
    import ocmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [3:0]      wr_addr,
    input  logic [CW-1:0]   wr_data,
    input  logic [3:0]      rd_addr,
    output logic [CW-1:0]   rd_data,
    output logic [NCH-1:0]  pin_o
);
    localparam int MST = NCH - 1;

    logic                   run, wrap_en, ovf_en, at_max, master_evt, cnt_load;
    logic [NCH-1:0]         en, mask, level, match, flags, flag_clr;
    logic [2*NCH-1:0]       act;
    logic [NCH-1:0][CW-1:0] cmp;
    logic [CW-1:0]          cnt, master_cmp;

    assign cnt_load   = wr_en && (wr_addr == A_COUNT);
    assign flag_clr   = (wr_en && (wr_addr == A_FLAGS)) ? wr_data[NCH-1:0] : '0;
    assign master_cmp = cmp[MST];

    ocmp_regfile #(.NCH(NCH), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run_o(run), .wrap_o(wrap_en), .ovf_o(ovf_en), .en_o(en), .act_o(act),
        .mask_o(mask), .level_o(level), .cmp_o(cmp)
    );

    ocmp_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .wrap_en(wrap_en), .top(master_cmp),
        .load(cnt_load), .load_val(wr_data), .cnt_o(cnt), .at_max_o(at_max)
    );

    ocmp_compare #(.NCH(NCH), .CW(CW)) u_cmp (
        .run(run), .en(en), .ovf_en(ovf_en), .at_max(at_max), .cnt(cnt), .cmp(cmp),
        .match_o(match), .master_o(master_evt)
    );

    ocmp_outputs #(.NCH(NCH)) u_out (
        .clk(clk), .rst(rst), .act(act), .en(en), .match(match), .master(master_evt),
        .mask(mask), .level(level), .clr(flag_clr), .pins_o(pin_o), .flags_o(flags)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_COUNT:  rd_data = cnt;
            A_CTRL:   rd_data = CW'({ovf_en, wrap_en, run});
            A_ENABLE: rd_data = CW'(en);
            A_ACTION: rd_data = CW'(act);
            A_MASK:   rd_data = CW'(mask);
            A_LEVEL:  rd_data = CW'(level);
            A_FLAGS:  rd_data = CW'(flags);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (rd_addr == A_CMP0 + 4'(i)) rd_data = cmp[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [CW-1:0]   cnt,
    input logic            run,
    input logic            wrap_en,
    input logic [CW-1:0]   master_cmp,
    input logic            cnt_load,
    input logic [NCH-1:0]  match,
    input logic            master_evt,
    input logic [NCH-1:0]  en,
    input logic [NCH-1:0]  mask,
    input logic [NCH-1:0]  level,
    input logic [NCH-1:0]  pin_o,
    input logic [NCH-1:0]  flags,
    input logic [NCH-1:0]  flag_clr
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0 && pin_o == '0 && flags == '0));

    a_r3_count_up: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_load && !(wrap_en && cnt == master_cmp)) |=> cnt == $past(cnt) + CW'(1));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_load) |=> $stable(cnt));

    a_r11_period_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_load && wrap_en && cnt == master_cmp) |=> cnt == '0);

    a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((pin_o ^ $past(pin_o)) & ~$past(en)) == '0);

    a_r8_override: assert property (@(posedge clk) disable iff (rst)
        master_evt |=> ((pin_o ^ $past(level)) & $past(mask & en)) == '0);

    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($past(match) & ~flags) == '0);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($past(flags) & ~$past(flag_clr) & ~flags) == '0);
endmodule

bind ocmp_timer ocmp_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .cnt(cnt), .run(run), .wrap_en(wrap_en),
    .master_cmp(master_cmp), .cnt_load(cnt_load), .match(match),
    .master_evt(master_evt), .en(en), .mask(mask), .level(level),
    .pin_o(pin_o), .flags(flags), .flag_clr(flag_clr)
);

// File: tb/ocmp_timer_test.sv
module ocmp_timer_test;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int CW    = 16;

    localparam logic [3:0] R_CNT = 4'd0, R_CTL = 4'd1, R_EN = 4'd2, R_ACT = 4'd3;
    localparam logic [3:0] R_MSK = 4'd4, R_LVL = 4'd5, R_FLG = 4'd6, R_CMP = 4'd8;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data;
    logic [NCH-1:0] pin_o;
    logic [NCH-1:0] exp_pins = '0;
    logic [CW-1:0] v;
    int nchk = 0, nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    ocmp_timer #(.NCH(NCH), .CW(CW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_o(pin_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [CW-1:0] val);
        rd_addr = a;
        #1;
        val = rd_data;
    endtask

    // counts for exactly n cycles with control bits 'bits' (run bit forced)
    task automatic run(int n, logic [CW-1:0] bits);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = R_CTL; wr_data = bits | 16'h1;
        @(negedge clk);
        if (n > 1) begin
            wr_en = 1'b0;
            repeat (n - 1) @(negedge clk);
        end
        wr_en = 1'b1; wr_addr = R_CTL; wr_data = '0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic act_res(int m, logic p);
        case (m)
            0: return p;
            1: return ~p;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pins", 32'(pin_o), 32'h0);
        rd(R_FLG, v); chk("R1 flags", 32'(v), 32'h0);
        rd(R_CNT, v); chk("R1 counter", 32'(v), 32'h0);

        // R2/R3 load, count, hold, wrap
        wr(R_CNT, 16'h0010);
        rd(R_CNT, v); chk("R2 load", 32'(v), 32'h10);
        run(5, 16'h1);
        rd(R_CNT, v); chk("R3 count", 32'(v), 32'h15);
        repeat (3) @(negedge clk);
        rd(R_CNT, v); chk("R3 hold", 32'(v), 32'h15);
        wr(R_CNT, 16'hFFFE);
        run(3, 16'h1);
        rd(R_CNT, v); chk("R3 wrap", 32'(v), 32'h1);

        // R4 action sweep on channels 0..2
        wr(R_EN, 16'hF);
        wr(R_MSK, 16'h0);
        for (int i = 0; i < NCH; i++) wr(R_CMP + 4'(i), 16'(100 + 50 * i));
        for (int ch = 0; ch < 3; ch++) begin
            wr(R_CMP + 4'(ch), 16'd5);
            for (int p = 0; p < 2; p++) begin
                for (int m = 0; m < 4; m++) begin
                    wr(R_ACT, 16'(((p != 0) ? 3 : 2) << (2 * ch)));
                    wr(R_CNT, 16'd5);
                    run(1, 16'h1);
                    exp_pins[ch] = (p != 0);
                    wr(R_ACT, 16'(m << (2 * ch)));
                    wr(R_CNT, 16'd5);
                    run(1, 16'h1);
                    exp_pins[ch] = act_res(m, (p != 0));
                    chk("R4 action", 32'(pin_o), 32'(exp_pins));
                end
            end
            wr(R_CMP + 4'(ch), 16'(100 + 50 * ch));
        end

        // R6 flags
        wr(R_FLG, 16'hF);
        rd(R_FLG, v); chk("R6 clear all", 32'(v), 32'h0);
        wr(R_CMP, 16'd20);
        wr(R_CNT, 16'd20);
        repeat (3) @(negedge clk);
        rd(R_FLG, v); chk("R6 stopped no match", 32'(v), 32'h0);
        run(1, 16'h1);
        rd(R_FLG, v); chk("R6 set", 32'(v), 32'h1);
        repeat (2) @(negedge clk);
        rd(R_FLG, v); chk("R6 sticky", 32'(v), 32'h1);
        wr(R_FLG, 16'h2);
        rd(R_FLG, v); chk("R6 write0 keeps", 32'(v), 32'h1);
        wr(R_FLG, 16'h1);
        rd(R_FLG, v); chk("R6 w1c", 32'(v), 32'h0);
        chk("R6 pins", 32'(pin_o), 32'(exp_pins));

        // R5 disabled channel ignores own action and master
        wr(R_CMP + 4'd3, 16'd20);
        wr(R_EN, 16'hE);
        wr(R_ACT, 16'h1);
        wr(R_MSK, 16'h1);
        wr(R_LVL, 16'(~exp_pins[0]));
        wr(R_CNT, 16'd20);
        run(1, 16'h1);
        chk("R5 disabled", 32'(pin_o), 32'(exp_pins));
        wr(R_EN, 16'hF);
        wr(R_CMP, 16'd100);

        // R7/R8 master override sweep on channels 0..2
        wr(R_CMP + 4'd3, 16'd40);
        for (int ch = 0; ch < 3; ch++) begin
            wr(R_CMP + 4'(ch), 16'd40);
            for (int msk = 0; msk < 2; msk++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int m = 1; m < 4; m++) begin
                        wr(R_ACT, 16'(m << (2 * ch)));
                        wr(R_MSK, 16'(msk << ch));
                        wr(R_LVL, 16'(d << ch));
                        wr(R_CNT, 16'd40);
                        run(1, 16'h1);
                        exp_pins[ch] = (msk != 0) ? (d != 0) : act_res(m, exp_pins[ch]);
                        chk("R8 coincident", 32'(pin_o), 32'(exp_pins));
                    end
                end
            end
            wr(R_CMP + 4'(ch), 16'(100 + 50 * ch));
        end

        // R7 master only moves masked pins; R9 master own pin
        for (int msk = 0; msk < 2; msk++) begin
            for (int d = 0; d < 2; d++) begin
                for (int m = 1; m < 4; m++) begin
                    wr(R_ACT, 16'(m << 6));
                    wr(R_MSK, 16'(msk << 3));
                    wr(R_LVL, 16'(d << 3));
                    wr(R_CNT, 16'd40);
                    run(1, 16'h1);
                    exp_pins[3] = (msk != 0) ? (d != 0) : act_res(m, exp_pins[3]);
                    chk("R9 master pin", 32'(pin_o), 32'(exp_pins));
                end
            end
        end
        wr(R_MSK, 16'h3);
        wr(R_LVL, 16'(~{2'b00, exp_pins[1:0]} & 16'h3));
        wr(R_ACT, 16'h0);
        wr(R_CNT, 16'd40);
        run(1, 16'h1);
        exp_pins[1:0] = ~exp_pins[1:0];
        chk("R7 masked subset", 32'(pin_o), 32'(exp_pins));

        // R10 separate times: own action at 3, master at 6
        wr(R_CMP + 4'd3, 16'd6);
        wr(R_CMP + 4'd1, 16'd3);
        wr(R_ACT, 16'(3 << 2));
        wr(R_MSK, 16'h2);
        wr(R_LVL, 16'h0);
        wr(R_CNT, 16'd0);
        run(5, 16'h1);
        exp_pins[1] = 1'b1;
        chk("R10 first own action", 32'(pin_o), 32'(exp_pins));
        run(3, 16'h1);
        exp_pins[1] = 1'b0;
        chk("R10 then master level", 32'(pin_o), 32'(exp_pins));
        wr(R_CMP + 4'd1, 16'd150);

        // R13 overflow master event
        wr(R_CMP + 4'd3, 16'd500);
        wr(R_ACT, 16'h0);
        wr(R_MSK, 16'h4);
        wr(R_LVL, 16'({13'd0, ~exp_pins[2], 2'b00}));
        wr(R_CNT, 16'hFFFE);
        run(2, 16'h5);
        exp_pins[2] = ~exp_pins[2];
        chk("R13 overflow on", 32'(pin_o), 32'(exp_pins));
        rd(R_CNT, v); chk("R3 wrap to zero", 32'(v), 32'h0);
        wr(R_LVL, 16'({13'd0, ~exp_pins[2], 2'b00}));
        wr(R_CNT, 16'hFFFE);
        run(2, 16'h1);
        chk("R13 overflow off", 32'(pin_o), 32'(exp_pins));

        // R11/R12 PWM with period 9 and widths 0,3,8
        for (int wi = 0; wi < 3; wi++) begin
            int w;
            w = (wi == 0) ? 0 : ((wi == 1) ? 3 : 8);
            wr(R_CMP + 4'd3, 16'd9);
            wr(R_CMP, 16'(w));
            wr(R_ACT, 16'h3);
            wr(R_MSK, 16'h1);
            wr(R_LVL, 16'h0);
            wr(R_CNT, 16'd0);
            rd_addr = R_CNT;
            @(negedge clk);
            wr_en = 1'b1; wr_addr = R_CTL; wr_data = 16'h3;
            for (int k = 1; k <= 31; k++) begin
                @(negedge clk);
                wr_en = 1'b0;
                #1;
                v = rd_data;
                chk("R11 counter period", 32'(v), 32'((k - 1) % 10));
                if (k > 11)
                    chk("R12 pwm pin", 32'(pin_o[0]), 32'((v > 16'(w)) && (v <= 16'd9)));
            end
            wr(R_CTL, 16'h0);
            exp_pins[0] = pin_o[0];
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule